// File: doc/BRIEF.md
# Complementary Mosaic Luma Chroma Separator

This block sits directly behind the digitizer of a camera whose sensor carries a yellow, cyan, magenta and green mosaic. The sensor is read out with vertical pair mixing, so each digitized sample is already the sum of two filter colours. Along a line, two kinds of mixed sample alternate. On one line type these are green-plus-cyan and magenta-plus-yellow. On the other line type they are magenta-plus-cyan and green-plus-yellow.

The block pairs every sample with the one before it. The luma output is half the sum of the pair. The colour-difference output is the odd-phase sample minus the even-phase sample, where phase is counted from the start of the line. On the first line type this difference approximates R-Y. On the second it approximates the negative of B-Y. A one-bit tag goes with each result and says which of the two the chroma value carries. The tag flips on every line start and returns to the R-Y kind when a field starts.

Top module: `mosaic_luma_chroma_sep`

## Requirements
- R1: While reset is held and after it is released, `out_vld`, `luma`, `chroma` and `chroma_kind` are all zero.
- R2: A sample presented with `samp_vld` high before rising edge n produces its result on the outputs after rising edge n+1, which is two register stages.
- R3: A valid sample with `line_start` high produces no result. The first valid sample after reset produces no result. Every other valid sample produces exactly one result with `out_vld` high for one cycle.
- R4: `luma` equals floor((a+b)/2), where a and b are the two most recent valid samples.
- R5: `chroma` is a two's-complement value DATA_W+1 bits wide. It equals the odd-phase sample minus the even-phase sample of the pair. Phase is 0 for the sample that carries `line_start` and toggles with each later valid sample.
- R6: `chroma_kind` is 0 for R-Y and 1 for the negative of B-Y. It toggles on each valid sample that carries `line_start`, and the first line after reset is of kind 0.
- R7: A valid sample that carries both `line_start` and `field_start` sets the kind to 0 for that line, whatever the previous kind was.
- R8: Cycles with `samp_vld` low produce no result. They do not advance the phase and do not break the pairing of the samples on either side of them.
- R9: `line_start` and `field_start` have no effect in a cycle where `samp_vld` is low.
- R10: Full-scale inputs do not wrap. Luma reaches 2^DATA_W-1, and chroma reaches +(2^DATA_W-1) and -(2^DATA_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| samp_in | input | DATA_W | Mixed-pair sample, unsigned |
| samp_vld | input | 1 | Sample strobe |
| line_start | input | 1 | Marks the first sample of a line |
| field_start | input | 1 | With `line_start`, marks the first line of a field |
| out_vld | output | 1 | Result strobe |
| luma | output | DATA_W | Half the pair sum |
| chroma | output | DATA_W+1 | Signed odd-minus-even difference |
| chroma_kind | output | 1 | 0 = R-Y, 1 = negative of B-Y |

## Verification
The bench targets the subtraction order on both phases.
- A design that chose the order by comparing magnitudes, or by which sample is the current one, would flip the sign of chroma on every other result.
- Idle gaps in the middle of a line must not advance the phase. If they did, the chroma sign would invert after each gap.
- A line-start strobe without a valid sample must be ignored. A design that acted on it would drop a result and toggle the kind early.
- Field starts are driven on both kinds of preceding line. A design that toggled the kind there, instead of forcing it to 0, fails on half of them.
- Full-scale and zero samples expose any missing extension bit in the sum or the difference.

// File: rtl/mlcs_pkg.sv
package mlcs_pkg;

   // Meaning of the colour-difference output for one line
   typedef enum logic {
      KIND_R_MINUS_Y  = 1'b0,
      KIND_NEG_B_MINUS_Y = 1'b1
   } line_kind_e;

   // Kind used for a new line
   function automatic line_kind_e next_kind(input line_kind_e cur, input logic new_field);
      if (new_field) return KIND_R_MINUS_Y;
      return (cur == KIND_R_MINUS_Y) ? KIND_NEG_B_MINUS_Y : KIND_R_MINUS_Y;
   endfunction

endpackage

// File: rtl/mlcs_pair_track.sv
module mlcs_pair_track
   import mlcs_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] samp_in,
   input  logic              samp_vld,
   input  logic              line_start,
   input  logic              field_start,
   output logic [DATA_W-1:0] cur_q,
   output logic [DATA_W-1:0] prev_q,
   output logic              odd_q,
   output logic              pair_q,
   output logic              vld_q,
   output line_kind_e        kind_q
);

   logic seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
         odd_q  <= 1'b0;
         pair_q <= 1'b0;
         vld_q  <= 1'b0;
         seen_q <= 1'b0;
         kind_q <= KIND_R_MINUS_Y;
      end else begin
         vld_q <= samp_vld;
         if (samp_vld) begin
            prev_q <= cur_q;
            cur_q  <= samp_in;
            seen_q <= 1'b1;
            if (line_start) begin
               odd_q  <= 1'b0;
               pair_q <= 1'b0;
               kind_q <= next_kind(kind_q, field_start);
            end else begin
               odd_q  <= seen_q ? ~odd_q : 1'b0;
               pair_q <= seen_q;
            end
         end else begin
            pair_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/mlcs_pair_math.sv
module mlcs_pair_math #(
   parameter int DATA_W     = 10,
   parameter bit LUMA_ROUND = 1'b0
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] prev,
   input  logic              odd,
   output logic [DATA_W-1:0] luma,
   output logic [DATA_W:0]   chroma
);

   localparam int SUM_W = DATA_W + 2;

   logic [SUM_W-1:0] sum_w;
   logic [DATA_W:0]  cur_x;
   logic [DATA_W:0]  prev_x;

   assign cur_x  = {1'b0, cur};
   assign prev_x = {1'b0, prev};
   assign sum_w  = {1'b0, cur_x} + {1'b0, prev_x};

   generate
      if (LUMA_ROUND) begin : g_round
         logic [SUM_W-1:0] sum_r;
         assign sum_r = sum_w + SUM_W'(1);
         assign luma  = sum_r[DATA_W:1];
      end else begin : g_trunc
         assign luma = sum_w[DATA_W:1];
      end
   endgenerate

   // Order comes from phase within the line, never from magnitude
   assign chroma = odd ? (cur_x - prev_x) : (prev_x - cur_x);

endmodule

// File: rtl/mlcs_out_stage.sv
module mlcs_out_stage
   import mlcs_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] luma_d,
   input  logic [DATA_W:0]   chroma_d,
   input  line_kind_e        kind_d,
   output logic              vld_o,
   output logic [DATA_W-1:0] luma_o,
   output logic [DATA_W:0]   chroma_o,
   output logic              kind_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o    <= 1'b0;
         luma_o   <= '0;
         chroma_o <= '0;
         kind_o   <= 1'b0;
      end else begin
         vld_o <= take;
         if (take) begin
            luma_o   <= luma_d;
            chroma_o <= chroma_d;
            kind_o   <= kind_d;
         end
      end
   end

endmodule

// File: rtl/mosaic_luma_chroma_sep.sv
module mosaic_luma_chroma_sep
   import mlcs_pkg::*;
#(
   parameter int DATA_W     = 10,
   parameter bit LUMA_ROUND = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] samp_in,
   input  logic              samp_vld,
   input  logic              line_start,
   input  logic              field_start,
   output logic              out_vld,
   output logic [DATA_W-1:0] luma,
   output logic [DATA_W:0]   chroma,
   output logic              chroma_kind
);

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("mosaic_luma_chroma_sep: DATA_W must lie in 2..16");
      end
   endgenerate

   logic [DATA_W-1:0] cur_s;
   logic [DATA_W-1:0] prev_s;
   logic              odd_s;
   logic              pair_s;
   logic              vld_s;
   line_kind_e        kind_s;
   logic [DATA_W-1:0] luma_c;
   logic [DATA_W:0]   chroma_c;

   mlcs_pair_track #(.DATA_W(DATA_W)) track_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .samp_in     (samp_in),
      .samp_vld    (samp_vld),
      .line_start  (line_start),
      .field_start (field_start),
      .cur_q       (cur_s),
      .prev_q      (prev_s),
      .odd_q       (odd_s),
      .pair_q      (pair_s),
      .vld_q       (vld_s),
      .kind_q      (kind_s)
   );

   mlcs_pair_math #(.DATA_W(DATA_W), .LUMA_ROUND(LUMA_ROUND)) math_i (
      .cur    (cur_s),
      .prev   (prev_s),
      .odd    (odd_s),
      .luma   (luma_c),
      .chroma (chroma_c)
   );

   mlcs_out_stage #(.DATA_W(DATA_W)) out_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (vld_s & pair_s),
      .luma_d   (luma_c),
      .chroma_d (chroma_c),
      .kind_d   (kind_s),
      .vld_o    (out_vld),
      .luma_o   (luma),
      .chroma_o (chroma),
      .kind_o   (chroma_kind)
   );

endmodule

// File: rtl/mlcs_checker.sv
module mlcs_checker #(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              samp_vld,
   input logic              line_start,
   input logic              out_vld,
   input logic [DATA_W:0]   chroma,
   input logic              chroma_kind
);

   // R2 R8: a result needs a valid sample two edges earlier
   a_r8_result_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(samp_vld, 2));

   // R3: a line-opening sample yields nothing
   a_r3_no_result_on_line_open: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> !$past(line_start && samp_vld, 2));

   // R6: back-to-back results share one line, so one kind
   a_r6_kind_steady_in_line: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && $past(out_vld)) |-> (chroma_kind == $past(chroma_kind)));

   // R10: the difference never reaches the most negative code
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (chroma != {1'b1, {DATA_W{1'b0}}}));

endmodule

bind mosaic_luma_chroma_sep mlcs_checker #(.DATA_W(DATA_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .samp_vld    (samp_vld),
   .line_start  (line_start),
   .out_vld     (out_vld),
   .chroma      (chroma),
   .chroma_kind (chroma_kind)
);

// File: tb/mosaic_luma_chroma_sep_tb.sv
module mosaic_luma_chroma_sep_tb_top;

   localparam int DW   = 10;
   localparam int MAXV = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] samp_in = '0;
   logic          samp_vld = 1'b0;
   logic          line_start = 1'b0;
   logic          field_start = 1'b0;
   logic          out_vld;
   logic [DW-1:0] luma;
   logic [DW:0]   chroma;
   logic          chroma_kind;

   always #2 clk = ~clk;

   mosaic_luma_chroma_sep #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .samp_vld(samp_vld),
      .line_start(line_start), .field_start(field_start),
      .out_vld(out_vld), .luma(luma), .chroma(chroma), .chroma_kind(chroma_kind)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 0;

   // model state
   int    m_kind = 0;
   int    m_odd  = 0;
   int    m_seen = 0;
   int    m_prev = 0;
   string ctx = "R4";

   // two-deep expectation pipe
   bit    e_vld[2];
   int    e_luma[2];
   int    e_chr[2];
   int    e_kind[2];
   string e_ctx[2];
   string e_kreq[2];

   function automatic int ref_luma(int a, int b);
      return (a + b) / 2;
   endfunction

   function automatic int ref_chroma(int cur, int prev, int odd);
      return odd ? (cur - prev) : (prev - cur);
   endfunction

   task automatic expect_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_out();
      expect_eq("R2 R3 R8", "out_vld", int'(out_vld), int'(e_vld[1]));
      if (e_vld[1] && out_vld) begin
         expect_eq((e_ctx[1] == "R10") ? "R10" : "R4", "luma", int'(luma), e_luma[1]);
         expect_eq((e_ctx[1] == "R10") ? "R10" : "R5", "chroma", int'($signed(chroma)), e_chr[1]);
         expect_eq(e_kreq[1], "chroma_kind", int'(chroma_kind), e_kind[1]);
      end
   endtask

   task automatic step(bit v, bit ls, bit fs, int d);
      bit    pv;
      int    lu;
      int    ch;
      string kreq;
      @(negedge clk);
      if (done) return;
      check_out();
      e_vld[1] = e_vld[0]; e_luma[1] = e_luma[0]; e_chr[1] = e_chr[0];
      e_kind[1] = e_kind[0]; e_ctx[1] = e_ctx[0]; e_kreq[1] = e_kreq[0];
      pv = 0; lu = 0; ch = 0; kreq = "R6";
      if (v) begin
         if (ls) begin
            m_kind = fs ? 0 : 1 - m_kind;
            m_odd  = 0;
         end else begin
            if (m_seen != 0) begin
               m_odd = 1 - m_odd;
               pv = 1;
               lu = ref_luma(d, m_prev);
               ch = ref_chroma(d, m_prev, m_odd);
            end else begin
               m_odd = 0;
            end
         end
         m_seen = 1;
         m_prev = d;
      end
      if (ls && fs && v) kreq = "R7";
      e_vld[0] = pv; e_luma[0] = lu; e_chr[0] = ch; e_kind[0] = m_kind;
      e_ctx[0] = ctx; e_kreq[0] = kreq;
      samp_vld = v; line_start = ls; field_start = fs; samp_in = DW'(d);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0);
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000 && !done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      e_vld = '{0, 0}; e_luma = '{0, 0}; e_chr = '{0, 0}; e_kind = '{0, 0};
      e_ctx = '{"R4", "R4"}; e_kreq = '{"R6", "R6"};
      repeat (4) @(negedge clk);
      // R1: values held in reset
      expect_eq("R1", "out_vld in reset", int'(out_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_eq("R1", "out_vld", int'(out_vld), 0);
      expect_eq("R1", "luma", int'(luma), 0);
      expect_eq("R1", "chroma", int'(chroma), 0);
      expect_eq("R1", "chroma_kind", int'(chroma_kind), 0);

      // R3: samples before any line start; first has no partner, kind stays 0
      step(1, 0, 0, 100); step(1, 0, 0, 40); step(1, 0, 0, 70);
      // R6: line start without field start toggles kind to 1
      step(1, 1, 0, 200); step(1, 0, 0, 50); step(1, 0, 0, 300);
      // R8: gaps inside a line
      ctx = "R8";
      step(0, 0, 0, 999); step(0, 0, 0, 1); step(1, 0, 0, 10);
      step(0, 0, 0, 0); step(1, 0, 0, 500);
      // R9: strobes without sample are ignored
      ctx = "R9";
      step(0, 1, 1, 0); step(1, 0, 0, 20); step(0, 1, 0, 5); step(1, 0, 0, 600);
      // R7: field start when previous kind is 1 and when it is 0
      ctx = "R4";
      step(1, 1, 1, 11); step(1, 0, 0, 22);
      step(1, 1, 1, 33); step(1, 0, 0, 44);
      // R10: full-scale extremes in both phases
      ctx = "R10";
      step(1, 1, 0, MAXV); step(1, 0, 0, 0); step(1, 0, 0, MAXV);
      step(1, 0, 0, MAXV); step(1, 0, 0, 0); step(1, 0, 0, 0);
      idle(3);

      // constrained random lines
      for (int ln = 0; ln < 60; ln++) begin
         int nsamp;
         bit ext;
         nsamp = 6 + int'($urandom % 24);
         ext   = (ln % 7 == 3);
         ctx   = ext ? "R10" : "R4";
         for (int s = 0; s < nsamp; s++) begin
            int d;
            if (ext) d = ($urandom % 2) ? MAXV : 0;
            else     d = int'($urandom % (MAXV + 1));
            if (s != 0 && ($urandom % 4) == 0) step(0, $urandom % 2, $urandom % 2, 0);
            step(1, s == 0, (s == 0) && (ln % 9 == 0 || ($urandom % 6) == 0), d);
         end
         idle(int'($urandom % 3));
      end
      idle(4);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule